// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

A memory-mapped general-purpose I/O controller that groups its pins into banks of 32, with between one and seven banks fitted. Software reaches each bank through a small 32-bit register bus. Outputs are changed only by write-one set and clear strobes. Each pin can be turned into an output through a direction register, and selected pins can have the polarity of that register flipped by a parameter. Pad inputs pass through a synchroniser. The synchronised values feed a per-pin edge detector with separate rising and falling enables.

Detected edges latch into a status register that software clears by writing ones. A per-bank mask decides which status bits reach the interrupt logic. One combined interrupt covers every pin. Pins 0 and 1 of bank 0 also each drive a dedicated interrupt line.

Three banks share each 256-byte group, at a stride of one word. Bank n sits at byte address ((n / 3) << 8) + ((n % 3) << 2). Reads return data one clock after the read strobe.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register is zero. pad_out is all zero, and pad_oe is 1 only where INV_MASK is 1. All three interrupt outputs are low.
- R2: A register's byte address is the bank base plus the register offset. The bank base is ((n / 3) << 8) + ((n % 3) << 2). The offsets are: 0x00 level, 0x0C direction, 0x18 set, 0x24 clear, 0x30 rising enable, 0x3C falling enable, 0x48 edge status, 0x9C edge mask.
- R3: Writing a word to the set register drives high each output latch bit whose data bit is 1. Writing to the clear register drives each such bit low. A data bit of 0 leaves the latch bit unchanged. Both registers read as zero.
- R4: pad_oe for a pin is its direction bit XOR its INV_MASK bit. A direction bit of 1 makes a non-inverted pin an output.
- R5: The level register returns the output latch bit for pins whose pad_oe is 1. For the other pins it returns the synchronised pad value.
- R6: A rising transition of a synchronised pad sets its status bit when the rising enable is 1. A falling transition does the same when the falling enable is 1. With both enables at 0 no status bit is set.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new enabled edge on the same pin fall in the same cycle, the bit stays set.
- R8: irq_mux is high while any bank has a status bit set whose mask bit is 1. A set status bit with mask 0 does not raise it.
- R9: irq_pin0 and irq_pin1 follow status AND mask for bits 0 and 1 of bank 0.
- R10: Reads of a bank index at or above NUM_BANKS return zero, and so do reads of an undefined offset or a misaligned address. Writes to such addresses change no implemented register.
- R11: rdata is registered: it shows the addressed value in the cycle after rd_en, and zero after a cycle without rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| pad_in | input | NUM_BANKS*32 | Raw pad inputs, bank 0 in the low word |
| pad_out | output | NUM_BANKS*32 | Output latch values |
| pad_oe | output | NUM_BANKS*32 | Output enables |
| irq_mux | output | 1 | Combined interrupt, level high |
| irq_pin0 | output | 1 | Dedicated interrupt of pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt of pin 1 |

## Verification
A corrupted latch or direction bit shows on pad_out or pad_oe in the clock after the write that caused it. A wrong status or mask bit shows on the interrupt outputs in that same cycle, or three cycles after the pad transition through the two synchroniser stages and the status flop. A decode fault that aliases banks shows as a read of one bank returning a value written to another, one cycle after rd_en. The directed tests therefore read back through neighbouring bank addresses and sample the pads and interrupts at those exact cycles.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

   localparam int PINS_PER_BANK = 32;
   localparam int MAX_BANKS     = 7;

   typedef enum logic [3:0] {
      REG_LEVEL,
      REG_DIR,
      REG_SET,
      REG_CLR,
      REG_RISE,
      REG_FALL,
      REG_STAT,
      REG_MASK,
      REG_NONE
   } reg_sel_e;

   typedef struct packed {
      logic       hit;
      logic [4:0] bank;
      reg_sel_e   sel;
   } dec_t;

   // slot = word offset within a group divided by three (register spacing 0x0C)
   function automatic reg_sel_e slot_to_reg(input logic [4:0] slot);
      case (slot)
         5'd0:    return REG_LEVEL;
         5'd1:    return REG_DIR;
         5'd2:    return REG_SET;
         5'd3:    return REG_CLR;
         5'd4:    return REG_RISE;
         5'd5:    return REG_FALL;
         5'd6:    return REG_STAT;
         5'd13:   return REG_MASK;
         default: return REG_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   logic [5:0] word;
   logic [2:0] group;
   logic [1:0] lane;
   logic [4:0] slot;
   logic       upper_ok;
   reg_sel_e   sel;
   logic [4:0] bank;

   assign word  = addr[7:2];
   assign group = addr[10:8];
   assign lane  = 2'(word % 6'd3);
   assign slot  = 5'(word / 6'd3);
   assign sel   = slot_to_reg(slot);
   assign bank  = 5'(group) * 5'd3 + {3'b000, lane};

   generate
      if (ADDR_W > 11) begin : g_upper
         assign upper_ok = ~|addr[ADDR_W-1:11];
      end else begin : g_no_upper
         assign upper_ok = 1'b1;
      end
   endgenerate

   assign dec.hit  = upper_ok && (addr[1:0] == 2'b00) &&
                     (bank < 5'(NUM_BANKS)) && (sel != REG_NONE);
   assign dec.bank = bank;
   assign dec.sel  = sel;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_ctrl_pkg::*;
#(
   parameter int                       SYNC_STAGES = 2,
   parameter logic [PINS_PER_BANK-1:0] INV         = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [PINS_PER_BANK-1:0] pad_in,
   input  logic                     wr_en,
   input  reg_sel_e                 sel,
   input  logic [PINS_PER_BANK-1:0] wdata,
   output logic [PINS_PER_BANK-1:0] rd_data,
   output logic [PINS_PER_BANK-1:0] pad_out,
   output logic [PINS_PER_BANK-1:0] pad_oe,
   output logic [PINS_PER_BANK-1:0] irq_bits
);
   localparam int N = PINS_PER_BANK;

   logic [N-1:0] synced, prev;
   logic [N-1:0] dir_q, latch_q, rise_q, fall_q, stat_q, mask_q;
   logic [N-1:0] new_edge, stat_clr, level;

   gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(synced)
   );

   assign new_edge = (rise_q & synced & ~prev) | (fall_q & ~synced & prev);
   assign stat_clr = (wr_en && sel == REG_STAT) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         latch_q <= '0;
         rise_q  <= '0;
         fall_q  <= '0;
         stat_q  <= '0;
         mask_q  <= '0;
         prev    <= '0;
      end else begin
         if (wr_en) begin
            case (sel)
               REG_DIR:  dir_q   <= wdata;
               REG_SET:  latch_q <= latch_q | wdata;
               REG_CLR:  latch_q <= latch_q & ~wdata;
               REG_RISE: rise_q  <= wdata;
               REG_FALL: fall_q  <= wdata;
               REG_MASK: mask_q  <= wdata;
               default:  ;
            endcase
         end
         prev   <= synced;
         // a fresh edge overrides a simultaneous write-one clear
         stat_q <= (stat_q & ~stat_clr) | new_edge;
      end
   end

   assign pad_oe   = dir_q ^ INV;
   assign pad_out  = latch_q;
   assign level    = (pad_oe & latch_q) | (~pad_oe & synced);
   assign irq_bits = stat_q & mask_q;

   always_comb begin
      case (sel)
         REG_LEVEL: rd_data = level;
         REG_DIR:   rd_data = dir_q;
         REG_RISE:  rd_data = rise_q;
         REG_FALL:  rd_data = fall_q;
         REG_STAT:  rd_data = stat_q;
         REG_MASK:  rd_data = mask_q;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_ctrl_pkg::*;
#(
   parameter int                         NUM_BANKS   = 3,
   parameter int                         ADDR_W      = 12,
   parameter int                         SYNC_STAGES = 2,
   parameter logic [NUM_BANKS*32-1:0]    INV_MASK    = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [31:0]             wdata,
   output logic [31:0]             rdata,
   input  logic [NUM_BANKS*32-1:0] pad_in,
   output logic [NUM_BANKS*32-1:0] pad_out,
   output logic [NUM_BANKS*32-1:0] pad_oe,
   output logic                    irq_mux,
   output logic                    irq_pin0,
   output logic                    irq_pin1
);
   localparam int N = PINS_PER_BANK;

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must lie between 1 and 7");
      end
      if (ADDR_W < 11) begin : g_bad_addr
         $error("ADDR_W must be at least 11");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   dec_t        dec;
   logic [N-1:0] bank_rd  [NUM_BANKS];
   logic [N-1:0] bank_irq [NUM_BANKS];
   logic [N-1:0] rd_sel;

   gpio_addr_dec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) dec_i (
      .addr(addr), .dec(dec)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic bank_wr;
         assign bank_wr = wr_en && dec.hit && (dec.bank == 5'(b));
         gpio_bank #(
            .SYNC_STAGES(SYNC_STAGES),
            .INV        (INV_MASK[b*N +: N])
         ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad_in  (pad_in[b*N +: N]),
            .wr_en   (bank_wr),
            .sel     (dec.sel),
            .wdata   (wdata),
            .rd_data (bank_rd[b]),
            .pad_out (pad_out[b*N +: N]),
            .pad_oe  (pad_oe[b*N +: N]),
            .irq_bits(bank_irq[b])
         );
      end
   endgenerate

   always_comb begin
      rd_sel  = '0;
      irq_mux = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (dec.hit && dec.bank == 5'(b)) rd_sel = bank_rd[b];
         irq_mux = irq_mux | (|bank_irq[b]);
      end
   end

   assign irq_pin0 = bank_irq[0][0];
   assign irq_pin1 = bank_irq[0][1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rd_en ? rd_sel : '0;
   end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
   parameter int NUM_BANKS = 3,
   parameter int ADDR_W    = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic [31:0]       rdata,
   input logic [31:0]       pad_out0,
   input logic              irq_mux,
   input logic              irq_pin0,
   input logic              irq_pin1
);
   logic [4:0] bank_idx;
   logic       unimpl;

   assign bank_idx = 5'(addr[10:8]) * 5'd3 + 5'(addr[7:2] % 6'd3);
   assign unimpl   = ((addr >> 11) != '0) || (addr[1:0] != 2'b00) ||
                     (bank_idx >= 5'(NUM_BANKS));

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_mux && !irq_pin0 && !irq_pin1));

   a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'('h018)) |=> ((pad_out0 & $past(wdata)) == $past(wdata)));

   a_r3_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'('h024)) |=> ((pad_out0 & $past(wdata)) == 32'h0));

   a_r9_pin0_in_mux: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pin0 |-> irq_mux);

   a_r9_pin1_in_mux: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pin1 |-> irq_mux);

   a_r10_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && unimpl) |=> (rdata == 32'h0));

   a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == 32'h0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .pad_out0(pad_out[31:0]),
   .irq_mux (irq_mux),
   .irq_pin0(irq_pin0),
   .irq_pin1(irq_pin1)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NB         = 4;
   localparam int AW         = 12;
   localparam logic [NB*32-1:0] INV = 128'h8000_0000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic            rd_en = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NB*32-1:0] pad_in = '0;
   logic [NB*32-1:0] pad_out, pad_oe;
   logic            irq_mux, irq_pin0, irq_pin1;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .SYNC_STAGES(2), .INV_MASK(INV)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .irq_mux(irq_mux), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 pad_oe", pad_oe, 128'h8000_0000);
      check("R1 pad_out", pad_out, '0);
      check("R1 irqs", {irq_mux, irq_pin0, irq_pin1}, 0);
      bus_rd(12'h00C, d);
      check("R1 dir reg", d, 0);
      @(negedge clk);
      check("R11 rdata idle", rdata, 0);
   endtask

   task automatic t_setclr();
      logic [31:0] d;
      bus_wr(12'h018, 32'h0000_00F0);
      check("R3 set", pad_out[31:0], 32'h0000_00F0);
      bus_wr(12'h024, 32'h0000_0030);
      check("R3 clear", pad_out[31:0], 32'h0000_00C0);
      bus_wr(12'h018, 32'h0);
      check("R3 zero set no effect", pad_out[31:0], 32'h0000_00C0);
      bus_rd(12'h018, d);
      check("R3 set reads zero", d, 0);
   endtask

   task automatic t_dir();
      bus_wr(12'h00C, 32'h8000_00FF);
      check("R4 direction with inversion", pad_oe[31:0], 32'h0000_00FF);
   endtask

   task automatic t_level();
      logic [31:0] d;
      pad_in[31:0] = 32'h8000_A50F;
      settle();
      bus_rd(12'h000, d);
      check("R5 level mix", d, 32'h8000_A5C0);
      pad_in[31:0] = 32'h0;
      settle();
   endtask

   task automatic t_edge();
      logic [31:0] d;
      bus_wr(12'h034, 32'h1);
      bus_wr(12'h040, 32'h2);
      pad_in[34:32] = 3'b111;
      settle();
      bus_rd(12'h04C, d);
      check("R6 rising only enabled", d, 32'h1);
      pad_in[34:32] = 3'b000;
      settle();
      bus_rd(12'h04C, d);
      check("R6 falling enabled, bit2 none", d, 32'h3);
      check("R8 unmasked status no irq", irq_mux, 0);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      bus_wr(12'h04C, 32'h2);
      bus_rd(12'h04C, d);
      check("R7 clear bit1", d, 32'h1);
      bus_wr(12'h04C, 32'h0);
      bus_rd(12'h04C, d);
      check("R7 zero write keeps", d, 32'h1);
      bus_wr(12'h04C, 32'h1);
      bus_rd(12'h04C, d);
      check("R7 clear bit0", d, 32'h0);
   endtask

   task automatic t_mask();
      pad_in[32] = 1'b1;
      settle();
      check("R8 masked off", irq_mux, 0);
      bus_wr(12'h0A0, 32'h1);
      check("R8 mask on raises irq", irq_mux, 1);
      check("R9 other bank no pin irq", {irq_pin0, irq_pin1}, 0);
      bus_wr(12'h04C, 32'h1);
      check("R8 cleared drops irq", irq_mux, 0);
   endtask

   task automatic t_dedicated();
      bus_wr(12'h030, 32'h3);
      bus_wr(12'h09C, 32'h3);
      pad_in[0] = 1'b1;
      settle();
      check("R9 pin0 line", {irq_mux, irq_pin0, irq_pin1}, 3'b110);
      pad_in[1] = 1'b1;
      settle();
      check("R9 pin1 line", {irq_mux, irq_pin0, irq_pin1}, 3'b111);
      bus_wr(12'h048, 32'h3);
      check("R9 cleared", {irq_mux, irq_pin0, irq_pin1}, 3'b000);
   endtask

   task automatic t_edge_wins();
      logic [31:0] d;
      bus_wr(12'h038, 32'h1);
      pad_in[64] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      bus_wr(12'h050, 32'h1);
      bus_rd(12'h050, d);
      check("R7 edge wins over clear", d, 32'h1);
   endtask

   task automatic t_map();
      logic [31:0] d;
      bus_wr(12'h014, 32'hA);
      check("R2 bank2 dir", pad_oe[95:64], 32'hA);
      bus_wr(12'h10C, 32'h5);
      check("R2 bank3 dir", pad_oe[127:96], 32'h5);
      bus_rd(12'h10C, d);
      check("R2 bank3 readback", d, 32'h5);
      bus_wr(12'h110, 32'hFFFF);
      bus_rd(12'h110, d);
      check("R10 bank4 reads zero", d, 0);
      bus_rd(12'h10C, d);
      check("R10 write to bank4 no alias", d, 32'h5);
      check("R10 pad_oe untouched", pad_oe, {32'h5, 32'hA, 32'h0, 32'h0000_00FF});
      bus_rd(12'h00D, d);
      check("R10 misaligned reads zero", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setclr();
      t_dir();
      t_level();
      t_edge();
      t_w1c();
      t_mask();
      t_dedicated();
      t_edge_wins();
      t_map();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule